// File: doc/BRIEF.md
# PLL Output Clock Divider with Software Gate

This block takes the fast core clock of a PLL and produces one or two output clocks. One output feeds the on-chip clock controller and an optional second output feeds an IO pad. Each output has its own 8-bit ratio field and its own enable bit. A ratio field of zero selects pass-through: the undivided core clock reaches the consumer only while the enable bit is set, and a latch-based gate keeps enable changes from cutting pulses short. Any nonzero ratio field forces the divided clock on, whatever the enable bit holds. In that case the output period is the ratio field plus one core cycles.

Each output keeps an active copy of its ratio field. A newly programmed ratio is copied into the active copy only when the current output period ends, so reprogramming never produces a truncated or stretched period. The pad output can be left out at elaboration for PLL instances that do not drive a pad. When it is left out, the pad output is held low.

Top module: `pll_out_divider`

## Requirements
- R1: With a nonzero ratio field D, the output clock repeats every D+1 core-clock cycles, so D=1 gives 2 cycles, D=2 gives 3 and D=255 gives 256.
- R2: With the ratio field at 0 and the enable bit at 1, the output follows the core clock: it is high in the core clock's high phase and low in its low phase.
- R3: With the ratio field at 0 and the enable bit at 0, the output stays low.
- R4: With a nonzero ratio field, the enable bit has no effect: the divided clock runs with the enable bit at 0.
- R5: After reset the active ratio is 0 and the enable bit is treated as 0, so both outputs are low until they are programmed.
- R6: In divided mode each period opens with a high phase of ceil((D+1)/2) core cycles and closes low for the rest. Even division ratios therefore give a 50 percent duty cycle, and odd ratios are high one cycle longer than they are low.
- R7: A ratio change made in the middle of a period takes effect only after that period ends. The running period keeps its old length and the next period has the new one.
- R8: When the pad output is left out at elaboration (HAS_IO_PATH = 0), the pad output stays low whatever its ratio field and enable bit hold.
- R9: The controller output and the pad output run independently, each from its own ratio field and enable bit.
- R10: In pass-through mode the enable bit is captured only while the core clock is low. An enable change during a high phase does not alter that phase, so no runt pulse appears.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_core | input | 1 | Core clock from the PLL |
| rst_n | input | 1 | Asynchronous active-low reset |
| ctl_div | input | 8 | Ratio field for the controller output (0 = pass-through) |
| ctl_en | input | 1 | Gate enable for the controller output, used only in pass-through |
| io_div | input | 8 | Ratio field for the pad output (0 = pass-through) |
| io_en | input | 1 | Gate enable for the pad output, used only in pass-through |
| ctl_clk_o | output | 1 | Clock to the clock controller |
| io_clk_o | output | 1 | Clock to the IO pad, low when the path is left out |

## Verification
The assertions run on every core-clock edge for each channel. They check that the period counter stays within the active ratio and steps by one between wraps, and that the active ratio changes only at a period boundary. They also check that a divided period opens high and closes low. The exact period and high-time lengths, pass-through gating, the glitch-free capture of the enable bit within a clock phase, the independence of the two outputs and the left-out pad path can only be seen at the output pins. The bench's scenarios show these by sampling the outputs in both phases of the core clock.

// File: rtl/pll_div_pkg.sv
`timescale 1ns/1ps
package pll_div_pkg;

  // Output period length in core cycles for a given ratio field.
  function automatic int unsigned period_len(input int unsigned ratio);
    return ratio + 1;
  endfunction

  // Number of leading high cycles in one divided period: ceil((ratio+1)/2).
  function automatic int unsigned high_span(input int unsigned ratio);
    return (ratio + 2) / 2;
  endfunction

endpackage

// File: rtl/pll_clk_gate.sv
`timescale 1ns/1ps
module pll_clk_gate (
  input  logic clk_i,
  input  logic en_i,
  output logic clk_o
);
  logic en_lat;

  // Transparent while the clock is low: enable settles before the high phase.
  always_latch begin
    if (!clk_i) en_lat = en_i;
  end

  assign clk_o = clk_i & en_lat;
endmodule

// File: rtl/pll_div_counter.sv
`timescale 1ns/1ps
module pll_div_counter #(
  parameter int DIV_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_n,
  input  logic [DIV_W-1:0] ratio_cfg,
  output logic [DIV_W-1:0] cnt_o,
  output logic [DIV_W-1:0] ratio_act_o,
  output logic             wrap_o,
  output logic             div_q_o
);
  import pll_div_pkg::*;

  logic [DIV_W-1:0] cnt_q;
  logic [DIV_W-1:0] ratio_q;
  logic             phase_q;
  logic [DIV_W-1:0] cnt_nxt;
  logic [DIV_W-1:0] ratio_nxt;
  logic             wrap;

  // Last core cycle of the current output period.
  assign wrap      = (cnt_q == ratio_q);
  // The programmed ratio is only picked up at a period boundary.
  assign ratio_nxt = wrap ? ratio_cfg : ratio_q;
  assign cnt_nxt   = wrap ? '0 : cnt_q + DIV_W'(1);

  always_ff @(posedge clk_i or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      ratio_q <= '0;
      phase_q <= 1'b0;
    end else begin
      cnt_q   <= cnt_nxt;
      ratio_q <= ratio_nxt;
      phase_q <= (32'(cnt_nxt) < high_span(32'(ratio_nxt)));
    end
  end

  assign cnt_o       = cnt_q;
  assign ratio_act_o = ratio_q;
  assign wrap_o      = wrap;
  assign div_q_o     = phase_q;
endmodule

// File: rtl/pll_div_chan.sv
`timescale 1ns/1ps
module pll_div_chan #(
  parameter int DIV_W = 8
) (
  input  logic             clk_core,
  input  logic             rst_n,
  input  logic [DIV_W-1:0] ratio_cfg,
  input  logic             en_cfg,
  output logic             clk_o,
  output logic [DIV_W-1:0] cnt_o,
  output logic [DIV_W-1:0] ratio_act_o,
  output logic             wrap_o,
  output logic             div_q_o,
  output logic             bypass_o
);
  logic gated_clk;
  logic div_q;
  logic [DIV_W-1:0] ratio_act;

  pll_div_counter #(.DIV_W(DIV_W)) cnt_i (
    .clk_i       (clk_core),
    .rst_n       (rst_n),
    .ratio_cfg   (ratio_cfg),
    .cnt_o       (cnt_o),
    .ratio_act_o (ratio_act),
    .wrap_o      (wrap_o),
    .div_q_o     (div_q)
  );

  pll_clk_gate gate_i (
    .clk_i (clk_core),
    .en_i  (en_cfg),
    .clk_o (gated_clk)
  );

  // A zero active ratio selects the gated pass-through path.
  assign bypass_o    = (ratio_act == '0);
  assign clk_o       = bypass_o ? gated_clk : div_q;
  assign ratio_act_o = ratio_act;
  assign div_q_o     = div_q;
endmodule

// File: rtl/pll_out_divider.sv
`timescale 1ns/1ps
module pll_out_divider #(
  parameter int DIV_W       = 8,
  parameter bit HAS_IO_PATH = 1'b1
) (
  input  logic             clk_core,
  input  logic             rst_n,
  input  logic [DIV_W-1:0] ctl_div,
  input  logic             ctl_en,
  input  logic [DIV_W-1:0] io_div,
  input  logic             io_en,
  output logic             ctl_clk_o,
  output logic             io_clk_o
);
  // Named internal events brought out for the checker.
  logic [DIV_W-1:0] ctl_cnt, ctl_ratio_act;
  logic             ctl_wrap, ctl_div_q, ctl_bypass;
  logic [DIV_W-1:0] io_cnt, io_ratio_act;
  logic             io_wrap, io_div_q, io_bypass;

  pll_div_chan #(.DIV_W(DIV_W)) ctl_chan_i (
    .clk_core    (clk_core),
    .rst_n       (rst_n),
    .ratio_cfg   (ctl_div),
    .en_cfg      (ctl_en),
    .clk_o       (ctl_clk_o),
    .cnt_o       (ctl_cnt),
    .ratio_act_o (ctl_ratio_act),
    .wrap_o      (ctl_wrap),
    .div_q_o     (ctl_div_q),
    .bypass_o    (ctl_bypass)
  );

  generate
    if (HAS_IO_PATH) begin : g_io
      pll_div_chan #(.DIV_W(DIV_W)) io_chan_i (
        .clk_core    (clk_core),
        .rst_n       (rst_n),
        .ratio_cfg   (io_div),
        .en_cfg      (io_en),
        .clk_o       (io_clk_o),
        .cnt_o       (io_cnt),
        .ratio_act_o (io_ratio_act),
        .wrap_o      (io_wrap),
        .div_q_o     (io_div_q),
        .bypass_o    (io_bypass)
      );
    end else begin : g_no_io
      logic unused_io;
      assign unused_io    = ^{io_div, io_en};
      assign io_clk_o     = 1'b0;
      assign io_cnt       = '0;
      assign io_ratio_act = '0;
      assign io_wrap      = 1'b1;
      assign io_div_q     = 1'b0;
      assign io_bypass    = 1'b1;
    end
  endgenerate
endmodule

// File: rtl/pll_div_chk.sv
`timescale 1ns/1ps
module pll_div_chk #(
  parameter int DIV_W = 8
) (
  input logic             clk_core,
  input logic             rst_n,
  input logic [DIV_W-1:0] cnt,
  input logic [DIV_W-1:0] ratio_act,
  input logic             wrap,
  input logic             div_q,
  input logic             bypass
);
  // R1
  cnt_bound_chk: assert property (@(posedge clk_core) disable iff (!rst_n)
    cnt <= ratio_act);

  // R1
  cnt_step_chk: assert property (@(posedge clk_core) disable iff (!rst_n)
    !wrap |=> (cnt == $past(cnt) + DIV_W'(1)));

  // R7
  ratio_hold_chk: assert property (@(posedge clk_core) disable iff (!rst_n)
    !wrap |=> $stable(ratio_act));

  // R6
  period_open_high_chk: assert property (@(posedge clk_core) disable iff (!rst_n)
    (!bypass && cnt == '0) |-> div_q);

  // R6
  period_close_low_chk: assert property (@(posedge clk_core) disable iff (!rst_n)
    (!bypass && wrap) |-> !div_q);
endmodule

bind pll_out_divider pll_div_chk #(.DIV_W(DIV_W)) ctl_chk_i (
  .clk_core  (clk_core),
  .rst_n     (rst_n),
  .cnt       (ctl_cnt),
  .ratio_act (ctl_ratio_act),
  .wrap      (ctl_wrap),
  .div_q     (ctl_div_q),
  .bypass    (ctl_bypass)
);

bind pll_out_divider pll_div_chk #(.DIV_W(DIV_W)) io_chk_i (
  .clk_core  (clk_core),
  .rst_n     (rst_n),
  .cnt       (io_cnt),
  .ratio_act (io_ratio_act),
  .wrap      (io_wrap),
  .div_q     (io_div_q),
  .bypass    (io_bypass)
);

// File: tb/pll_out_divider_tb_top.sv
`timescale 1ns/1ps
module pll_out_divider_tb_top;
  logic       clk_core = 1'b0;
  logic       rst_n    = 1'b0;
  logic [7:0] ctl_div  = 8'd0;
  logic       ctl_en   = 1'b0;
  logic [7:0] io_div   = 8'd0;
  logic       io_en    = 1'b0;
  logic       ctl_clk_o, io_clk_o;
  logic       n_ctl_clk_o, n_io_clk_o;

  int n_total = 0;
  int n_fail  = 0;

  always #2 clk_core = ~clk_core;

  pll_out_divider dut_i (
    .clk_core(clk_core), .rst_n(rst_n),
    .ctl_div(ctl_div), .ctl_en(ctl_en), .io_div(io_div), .io_en(io_en),
    .ctl_clk_o(ctl_clk_o), .io_clk_o(io_clk_o)
  );

  pll_out_divider #(.DIV_W(8), .HAS_IO_PATH(1'b0)) dut_noio_i (
    .clk_core(clk_core), .rst_n(rst_n),
    .ctl_div(ctl_div), .ctl_en(ctl_en), .io_div(io_div), .io_en(io_en),
    .ctl_clk_o(n_ctl_clk_o), .io_clk_o(n_io_clk_o)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    n_total++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic logic pick(input int sel);
    case (sel)
      0:       return ctl_clk_o;
      1:       return io_clk_o;
      2:       return n_io_clk_o;
      default: return n_ctl_clk_o;
    endcase
  endfunction

  // Sample one channel in the middle of the core clock's high phase.
  task automatic hi_sample(input int sel, output logic v);
    @(posedge clk_core); #1;
    v = pick(sel);
  endtask

  // Move to a point in the low phase, safe for changing inputs.
  task automatic to_low;
    @(posedge clk_core); #2.5;
  endtask

  // Measure one full output period and its high count in core cycles.
  task automatic measure(input int sel, output int per, output int hi);
    logic prev, cur;
    int guard = 0;
    hi_sample(sel, prev);
    forever begin
      hi_sample(sel, cur);
      guard++;
      if ((!prev && cur) || guard > 1200) break;
      prev = cur;
    end
    per = 1; hi = 1; prev = cur; guard = 0;
    forever begin
      hi_sample(sel, cur);
      guard++;
      if ((!prev && cur) || guard > 1200) break;
      per++;
      if (cur) hi++;
      prev = cur;
    end
  endtask

  task automatic t_reset;
    logic v;
    hi_sample(0, v); chk("R5", "ctl out in reset", v, 0);
    to_low; rst_n = 1'b1;
    for (int i = 0; i < 4; i++) begin
      hi_sample(0, v); chk("R5", "ctl out after reset", v, 0);
      #0; v = pick(1); chk("R5", "io out after reset", v, 0);
    end
  endtask

  task automatic t_pass_on;
    logic v;
    to_low; ctl_div = 8'd0; ctl_en = 1'b1;
    for (int i = 0; i < 3; i++) begin
      hi_sample(0, v); chk("R2", "pass-through high phase", v, 1);
      #2; chk("R2", "pass-through low phase", ctl_clk_o, 0);
    end
  endtask

  task automatic t_pass_off;
    logic v;
    to_low; ctl_div = 8'd0; ctl_en = 1'b0;
    hi_sample(0, v);
    for (int i = 0; i < 5; i++) begin
      hi_sample(0, v); chk("R3", "gated-off output", v, 0);
    end
  endtask

  task automatic t_ratio(input int d);
    int per, hi;
    to_low; ctl_div = 8'(d); ctl_en = 1'b1;
    measure(0, per, hi);
    chk("R1", $sformatf("period for ratio %0d", d), per, d + 1);
    chk("R6", $sformatf("high cycles for ratio %0d", d), hi, (d + 2) / 2);
  endtask

  task automatic t_en_ignored;
    int per, hi;
    to_low; ctl_div = 8'd3; ctl_en = 1'b0;
    measure(0, per, hi);
    chk("R4", "period with enable low", per, 4);
    chk("R4", "high cycles with enable low", hi, 2);
  endtask

  task automatic t_reprogram;
    logic prev, cur;
    int len = 0;
    int guard = 0;
    to_low; ctl_div = 8'd3;
    hi_sample(0, prev);
    forever begin
      hi_sample(0, cur); guard++;
      if ((!prev && cur) || guard > 100) break;
      prev = cur;
    end
    // In the first cycle of a period: reprogram mid-period.
    #1.5; ctl_div = 8'd1;
    len = 1; prev = cur; guard = 0;
    forever begin
      hi_sample(0, cur); guard++;
      if ((!prev && cur) || guard > 100) break;
      len++; prev = cur;
    end
    chk("R7", "running period keeps old length", len, 4);
    len = 1; prev = cur; guard = 0;
    forever begin
      hi_sample(0, cur); guard++;
      if ((!prev && cur) || guard > 100) break;
      len++; prev = cur;
    end
    chk("R7", "next period uses new length", len, 2);
  endtask

  task automatic t_no_runt;
    logic v;
    to_low; ctl_div = 8'd0; ctl_en = 1'b0;
    hi_sample(0, v); hi_sample(0, v);
    @(posedge clk_core); #0.5; ctl_en = 1'b1; #0.5;
    chk("R10", "enable raised in high phase has no effect", ctl_clk_o, 0);
    hi_sample(0, v); chk("R10", "enable taken at next high phase", v, 1);
    @(posedge clk_core); #0.5; ctl_en = 1'b0; #0.5;
    chk("R10", "enable dropped in high phase keeps pulse", ctl_clk_o, 1);
    #2; chk("R10", "low phase after drop", ctl_clk_o, 0);
    hi_sample(0, v); chk("R10", "gated after drop", v, 0);
  endtask

  task automatic t_independent;
    int per, hi;
    to_low; ctl_div = 8'd1; io_div = 8'd2; io_en = 1'b0;
    measure(0, per, hi); chk("R9", "ctl period", per, 2);
    measure(1, per, hi); chk("R9", "io period", per, 3);
    chk("R9", "io high cycles", hi, 2);
  endtask

  task automatic t_no_io;
    logic v;
    int per, hi;
    to_low; io_div = 8'd2; io_en = 1'b1; ctl_div = 8'd1;
    for (int i = 0; i < 8; i++) begin
      hi_sample(2, v); chk("R8", "left-out io high phase", v, 0);
    end
    to_low; io_div = 8'd0;
    for (int i = 0; i < 4; i++) begin
      hi_sample(2, v); chk("R8", "left-out io pass-through", v, 0);
    end
    measure(3, per, hi); chk("R8", "ctl still divides", per, 2);
  endtask

  initial begin
    #800000;
    n_total++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_total - n_fail, n_total);
    $finish;
  end

  initial begin
    int per, hi;
    repeat (3) @(posedge clk_core);
    t_reset;
    t_pass_on;
    t_pass_off;
    t_ratio(1);
    t_ratio(2);
    t_ratio(255);
    t_ratio(4);
    t_en_ignored;
    t_reprogram;
    t_no_runt;
    t_independent;
    t_no_io;
    // Back to zero ratio from divided mode: gate follows enable again.
    to_low; ctl_div = 8'd0; ctl_en = 1'b0;
    measure(0, per, hi);
    chk("R3", "gated after leaving divided mode", per > 1000 ? 1 : 0, 1);
    $display("%0d/%0d checks passed", n_total - n_fail, n_total);
    $finish;
  end
endmodule